// File: doc/BRIEF.md
# Partial Reconfiguration Handshake Sequencer

This block loads a partial reconfiguration image through a passive-parallel configuration port. After a start pulse it checks the mode-select and pin status inputs. It then brings up the port one step per clock cycle and uses an external clock-burst generator to flush the port. Next it raises the PR request, gives the lead-in clocks, and polls for the fabric's ready flag. Once ready is seen it accepts image words through a valid/ready handshake. On the final word it keeps only the valid low bytes.

After the last word the sequencer polls for the done flag. It then tears the port down in a fixed order, whether or not the done poll succeeded. If nothing has failed so far, it checks that the fabric reached user mode. A one-cycle done pulse ends the sequence, and a 2-bit result code stays held until the next start. A combinational summary of the status inputs is always available for software or a debug view.

Polls are not continuous. The status flags are sampled once per programmable interval of system clocks, and the number of samples is limited before a timeout is declared. The burst generator is reached through a start/done handshake, and the block holds the requested length stable until done returns.

Top module: `pr_seq_top`

## Requirements
- R1: On start, a mode select whose value is neither 3'b000 nor 3'b001 ends the sequence with result code 1 (invalid). In that case no burst is requested and the port controls keep their reset levels.
- R2: On start, if the nCONFIG or nSTATUS pin input is low, the sequence ends with result code 1. No burst is requested and the port controls stay at their reset levels.
- R3: Bring-up takes one step per cycle in this order: width select to 16-bit (`wide_o` low), divide-ratio code, chip enable low (`nce_o`), port enable, override enable. The ratio code is 0 for a plain image, 1 for encrypted only, and 2 whenever the image is compressed.
- R4: After bring-up, the block requests a 256-clock flush burst with PR request low. It then raises PR request and requests a 2047-clock lead burst. Each burst holds its length until `burst_done_i`.
- R5: Ready and done are sampled once every `poll_ivl_i` cycles (0 counts as 1). A PR error seen at a sample ends the wait with code 1. If the flag is absent for 10 samples, the wait ends with code 2, and the last sample falls 10 intervals after the wait begins.
- R6: On the final word (`word_last_i`), a byte count of 3, 2 or 1 keeps only the low 24, 16 or 8 bits and clears the rest. A count of 0 passes the full word.
- R7: The byte count has no effect on words that are not final; they pass unchanged.
- R8: The teardown order is: PR request low, a 256-clock flush burst, port disable, chip enable high, override disable. The same teardown runs after a failed ready or done wait.
- R9: If no earlier step failed, the result is 0 only when user mode, CONF_DONE and nSTATUS all read high after teardown; otherwise it is 2.
- R10: `summary_o` is 4 when user mode is high. Otherwise it is 3 when ready is high, then 2 on a CRC error, then 1 when nSTATUS is low, and 0 in all other cases.
- R11: After reset, chip enable is high, width select is high, and the other controls, `done_o` and `err_o` are low. `done_o` is a one-cycle pulse, and `err_o` holds its value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted while idle |
| encrypt_i | input | 1 | Image header says encrypted |
| compress_i | input | 1 | Image header says compressed |
| msel_i | input | 3 | Mode select status |
| ncfg_pin_i | input | 1 | nCONFIG pin status |
| nstat_pin_i | input | 1 | nSTATUS pin status |
| cdone_pin_i | input | 1 | CONF_DONE pin status |
| usermode_i | input | 1 | Fabric in user mode |
| crc_err_i | input | 1 | CRC error flag |
| pr_ready_i | input | 1 | PR ready flag |
| pr_done_i | input | 1 | PR done flag |
| pr_err_i | input | 1 | PR error flag |
| poll_ivl_i | input | IW | Cycles between status samples |
| burst_start_o | output | 1 | Burst request pulse |
| burst_len_o | output | BW | Requested burst length in clocks |
| burst_done_i | input | 1 | Burst finished |
| wide_o | output | 1 | Width select, low = 16-bit |
| ratio_o | output | 2 | Clock-to-data ratio code |
| nce_o | output | 1 | Chip enable, active low |
| port_en_o | output | 1 | Port clock and data enable |
| ovr_en_o | output | 1 | Override enable |
| pr_req_o | output | 1 | PR request |
| word_valid_i | input | 1 | Image word valid |
| word_data_i | input | DW | Image word |
| word_bytes_i | input | log2(DW/8) | Valid bytes on final word, 0 = all |
| word_last_i | input | 1 | Final word marker |
| word_ready_o | output | 1 | Sequencer accepts words |
| cfg_data_o | output | DW | Word sent to the port |
| cfg_valid_o | output | 1 | `cfg_data_o` valid this cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | End-of-sequence pulse |
| err_o | output | 2 | Result: 0 ok, 1 invalid/PR error, 2 timeout |
| summary_o | output | 3 | Decoded status summary |

## Verification
An FSM in the wrong state shows up first in the burst log. Bursts may be missing or extra, a length may be wrong, or the PR request level at a burst start may be wrong, and all of this is visible within a few cycles of the step in question. A poll counter that is off by one interval shifts the start of the teardown burst by whole intervals, so the bench measures that gap in exact cycles. A wrong mask or a wrong choice of word shows on `cfg_data_o` one cycle after the word is accepted. A bad result decision shows at the single `done_o` pulse.

// File: rtl/pr_seq_pkg.sv
package pr_seq_pkg;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_WIDTH,
    ST_RATIO,
    ST_NCE,
    ST_PORT,
    ST_OVR,
    ST_FL1_REQ,
    ST_FL1_WAIT,
    ST_PREQ,
    ST_LEAD_REQ,
    ST_LEAD_WAIT,
    ST_WAIT_RDY,
    ST_DATA,
    ST_WAIT_DONE,
    ST_DROP_REQ,
    ST_FL2_REQ,
    ST_FL2_WAIT,
    ST_T_PORT,
    ST_T_NCE,
    ST_T_OVR,
    ST_FINAL,
    ST_FIN
  } seq_state_e;

  localparam logic [1:0] ERR_OK  = 2'd0;
  localparam logic [1:0] ERR_BAD = 2'd1;
  localparam logic [1:0] ERR_TMO = 2'd2;

  typedef enum logic [2:0] {
    SUM_UNKNOWN   = 3'd0,
    SUM_RESET     = 3'd1,
    SUM_WR_ERR    = 3'd2,
    SUM_WRITING   = 3'd3,
    SUM_OPERATING = 3'd4
  } summary_e;

endpackage

// File: rtl/pr_rst_sync.sv
module pr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pr_poll_timer.sv
module pr_poll_timer #(
  parameter int IW        = 16,
  parameter int MAX_POLLS = 10,
  localparam int PW       = $clog2(MAX_POLLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [IW-1:0] ivl_i,
  output logic          tick_o,
  output logic          final_o
);
  logic [IW-1:0] cnt_q, cnt_d, ivl_m1;
  logic [PW-1:0] polls_q, polls_d;

  assign ivl_m1  = (ivl_i == '0) ? '0 : ivl_i - 1'b1;
  assign tick_o  = en_i && (cnt_q >= ivl_m1);
  assign final_o = (polls_q == PW'(MAX_POLLS - 1));

  always_comb begin
    cnt_d   = cnt_q;
    polls_d = polls_q;
    if (!en_i) begin
      cnt_d   = '0;
      polls_d = '0;
    end else if (tick_o) begin
      cnt_d = '0;
      if (!final_o) polls_d = polls_q + 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      polls_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      polls_q <= polls_d;
    end
  end
endmodule

// File: rtl/pr_word_mask.sv
module pr_word_mask #(
  parameter int DW  = 32,
  localparam int NB = DW / 8,
  localparam int CW = $clog2(NB)
) (
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] nbytes_i,
  input  logic          last_i,
  output logic [DW-1:0] data_o
);
  logic [NB-1:0] keep;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign keep[b] = !last_i || (nbytes_i == '0) || (int'(nbytes_i) > b);
    assign data_o[b*8 +: 8] = keep[b] ? data_i[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/pr_state_summary.sv
module pr_state_summary
  import pr_seq_pkg::*;
(
  input  logic     usermode_i,
  input  logic     pr_ready_i,
  input  logic     crc_err_i,
  input  logic     nstat_pin_i,
  output summary_e summary_o
);
  always_comb begin
    if (usermode_i)       summary_o = SUM_OPERATING;
    else if (pr_ready_i)  summary_o = SUM_WRITING;
    else if (crc_err_i)   summary_o = SUM_WR_ERR;
    else if (!nstat_pin_i) summary_o = SUM_RESET;
    else                  summary_o = SUM_UNKNOWN;
  end
endmodule

// File: rtl/pr_seq_top.sv
module pr_seq_top
  import pr_seq_pkg::*;
#(
  parameter int DW         = 32,
  parameter int IW         = 16,
  parameter int MAX_POLLS  = 10,
  parameter int BW         = 12,
  parameter int FLUSH_CLKS = 256,
  parameter int LEAD_CLKS  = 2047,
  localparam int NB        = DW / 8,
  localparam int CW        = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          encrypt_i,
  input  logic          compress_i,
  input  logic [2:0]    msel_i,
  input  logic          ncfg_pin_i,
  input  logic          nstat_pin_i,
  input  logic          cdone_pin_i,
  input  logic          usermode_i,
  input  logic          crc_err_i,
  input  logic          pr_ready_i,
  input  logic          pr_done_i,
  input  logic          pr_err_i,
  input  logic [IW-1:0] poll_ivl_i,
  output logic          burst_start_o,
  output logic [BW-1:0] burst_len_o,
  input  logic          burst_done_i,
  output logic          wide_o,
  output logic [1:0]    ratio_o,
  output logic          nce_o,
  output logic          port_en_o,
  output logic          ovr_en_o,
  output logic          pr_req_o,
  input  logic          word_valid_i,
  input  logic [DW-1:0] word_data_i,
  input  logic [CW-1:0] word_bytes_i,
  input  logic          word_last_i,
  output logic          word_ready_o,
  output logic [DW-1:0] cfg_data_o,
  output logic          cfg_valid_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    err_o,
  output logic [2:0]    summary_o
);
  seq_state_e    state_q, state_d;
  logic [1:0]    err_q, err_d;
  logic          wide_q, wide_d;
  logic [1:0]    ratio_q, ratio_d, ratio_code;
  logic          nce_q, nce_d;
  logic          port_q, port_d;
  logic          ovr_q, ovr_d;
  logic          preq_q, preq_d;
  logic          rst_n_s;
  logic          in_wait, poll_tick, poll_final;
  logic          accept, setup_bad, final_good;
  logic [DW-1:0] masked, cfg_data_q;
  logic          cfg_valid_q;
  summary_e      summary_w;

  pr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign in_wait = (state_q == ST_WAIT_RDY) || (state_q == ST_WAIT_DONE);

  pr_poll_timer #(.IW(IW), .MAX_POLLS(MAX_POLLS)) u_poll (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .en_i    (in_wait),
    .ivl_i   (poll_ivl_i),
    .tick_o  (poll_tick),
    .final_o (poll_final)
  );

  pr_word_mask #(.DW(DW)) u_mask (
    .data_i   (word_data_i),
    .nbytes_i (word_bytes_i),
    .last_i   (word_last_i),
    .data_o   (masked)
  );

  pr_state_summary u_sum (
    .usermode_i  (usermode_i),
    .pr_ready_i  (pr_ready_i),
    .crc_err_i   (crc_err_i),
    .nstat_pin_i (nstat_pin_i),
    .summary_o   (summary_w)
  );

  assign setup_bad  = (msel_i[2:1] != 2'b00) || !ncfg_pin_i || !nstat_pin_i;
  assign ratio_code = compress_i ? 2'd2 : (encrypt_i ? 2'd1 : 2'd0);
  assign final_good = usermode_i && cdone_pin_i && nstat_pin_i;
  assign accept     = (state_q == ST_DATA) && word_valid_i;

  // next-state and control-level decisions
  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    wide_d  = wide_q;
    ratio_d = ratio_q;
    nce_d   = nce_q;
    port_d  = port_q;
    ovr_d   = ovr_q;
    preq_d  = preq_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (setup_bad) begin
            err_d   = ERR_BAD;
            state_d = ST_FIN;
          end else begin
            err_d   = ERR_OK;
            state_d = ST_WIDTH;
          end
        end
      end
      ST_WIDTH: begin
        wide_d  = 1'b0;
        state_d = ST_RATIO;
      end
      ST_RATIO: begin
        ratio_d = ratio_code;
        state_d = ST_NCE;
      end
      ST_NCE: begin
        nce_d   = 1'b0;
        state_d = ST_PORT;
      end
      ST_PORT: begin
        port_d  = 1'b1;
        state_d = ST_OVR;
      end
      ST_OVR: begin
        ovr_d   = 1'b1;
        state_d = ST_FL1_REQ;
      end
      ST_FL1_REQ:  state_d = ST_FL1_WAIT;
      ST_FL1_WAIT: if (burst_done_i) state_d = ST_PREQ;
      ST_PREQ: begin
        preq_d  = 1'b1;
        state_d = ST_LEAD_REQ;
      end
      ST_LEAD_REQ:  state_d = ST_LEAD_WAIT;
      ST_LEAD_WAIT: if (burst_done_i) state_d = ST_WAIT_RDY;
      ST_WAIT_RDY: begin
        if (poll_tick) begin
          if (pr_err_i) begin
            err_d   = ERR_BAD;
            state_d = ST_DROP_REQ;
          end else if (pr_ready_i) begin
            state_d = ST_DATA;
          end else if (poll_final) begin
            err_d   = ERR_TMO;
            state_d = ST_DROP_REQ;
          end
        end
      end
      ST_DATA: if (word_valid_i && word_last_i) state_d = ST_WAIT_DONE;
      ST_WAIT_DONE: begin
        if (poll_tick) begin
          if (pr_err_i) begin
            err_d   = ERR_BAD;
            state_d = ST_DROP_REQ;
          end else if (pr_done_i) begin
            state_d = ST_DROP_REQ;
          end else if (poll_final) begin
            err_d   = ERR_TMO;
            state_d = ST_DROP_REQ;
          end
        end
      end
      ST_DROP_REQ: begin
        preq_d  = 1'b0;
        state_d = ST_FL2_REQ;
      end
      ST_FL2_REQ:  state_d = ST_FL2_WAIT;
      ST_FL2_WAIT: if (burst_done_i) state_d = ST_T_PORT;
      ST_T_PORT: begin
        port_d  = 1'b0;
        state_d = ST_T_NCE;
      end
      ST_T_NCE: begin
        nce_d   = 1'b1;
        state_d = ST_T_OVR;
      end
      ST_T_OVR: begin
        ovr_d   = 1'b0;
        state_d = (err_q == ERR_OK) ? ST_FINAL : ST_FIN;
      end
      ST_FINAL: begin
        if (!final_good) err_d = ERR_TMO;
        state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      err_q   <= ERR_OK;
      wide_q  <= 1'b1;
      ratio_q <= 2'd0;
      nce_q   <= 1'b1;
      port_q  <= 1'b0;
      ovr_q   <= 1'b0;
      preq_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      wide_q  <= wide_d;
      ratio_q <= ratio_d;
      nce_q   <= nce_d;
      port_q  <= port_d;
      ovr_q   <= ovr_d;
      preq_q  <= preq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cfg_data_q  <= '0;
      cfg_valid_q <= 1'b0;
    end else begin
      cfg_valid_q <= accept;
      if (accept) cfg_data_q <= masked;
    end
  end

  assign burst_start_o = (state_q == ST_FL1_REQ) || (state_q == ST_LEAD_REQ) ||
                         (state_q == ST_FL2_REQ);
  assign burst_len_o   = ((state_q == ST_LEAD_REQ) || (state_q == ST_LEAD_WAIT)) ?
                         BW'(LEAD_CLKS) : BW'(FLUSH_CLKS);
  assign wide_o        = wide_q;
  assign ratio_o       = ratio_q;
  assign nce_o         = nce_q;
  assign port_en_o     = port_q;
  assign ovr_en_o      = ovr_q;
  assign pr_req_o      = preq_q;
  assign word_ready_o  = (state_q == ST_DATA);
  assign cfg_data_o    = cfg_data_q;
  assign cfg_valid_o   = cfg_valid_q;
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = (state_q == ST_FIN);
  assign err_o         = err_q;
  assign summary_o     = summary_w;
endmodule

// File: rtl/pr_seq_chk.sv
module pr_seq_chk #(
  parameter int BW         = 12,
  parameter int FLUSH_CLKS = 256,
  parameter int LEAD_CLKS  = 2047
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [1:0]    err_o,
  input logic          nce_o,
  input logic          port_en_o,
  input logic          ovr_en_o,
  input logic          pr_req_o,
  input logic          word_ready_o,
  input logic          burst_start_o,
  input logic [BW-1:0] burst_len_o
);
  a_r3_port_after_nce: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_en_o) |-> !nce_o);
  a_r3_ovr_after_port: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_en_o) |-> port_en_o && !nce_o);
  a_r4_req_after_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pr_req_o) |-> ovr_en_o && port_en_o);
  a_r4_lead_len: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start_o && pr_req_o |-> burst_len_o == BW'(LEAD_CLKS));
  a_r4_flush_len: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start_o && !pr_req_o |-> burst_len_o == BW'(FLUSH_CLKS));
  a_r6_data_window: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready_o |-> pr_req_o && port_en_o && ovr_en_o && !nce_o);
  a_r8_nce_after_port_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nce_o) |-> !port_en_o && !pr_req_o);
  a_r8_ovr_off_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_en_o) |-> nce_o && !port_en_o);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r11_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(err_o));
endmodule

bind pr_seq_top pr_seq_chk #(
  .BW(BW), .FLUSH_CLKS(FLUSH_CLKS), .LEAD_CLKS(LEAD_CLKS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .err_o         (err_o),
  .nce_o         (nce_o),
  .port_en_o     (port_en_o),
  .ovr_en_o      (ovr_en_o),
  .pr_req_o      (pr_req_o),
  .word_ready_o  (word_ready_o),
  .burst_start_o (burst_start_o),
  .burst_len_o   (burst_len_o)
);

// File: tb/sim_pr_seq_top.sv
`timescale 1ns/1ps
module sim_pr_seq_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        start_i = 0, encrypt_i = 0, compress_i = 0;
  logic [2:0]  msel_i = 0;
  logic        ncfg_pin_i = 1, nstat_pin_i = 1, cdone_pin_i = 0, usermode_i = 0;
  logic        crc_err_i = 0, pr_ready_i = 0, pr_done_i = 0, pr_err_i = 0;
  logic [15:0] poll_ivl_i = 16'd4;
  logic        burst_start_o;
  logic [11:0] burst_len_o;
  logic        burst_done_i = 1'b0;
  logic        wide_o, nce_o, port_en_o, ovr_en_o, pr_req_o;
  logic [1:0]  ratio_o;
  logic        word_valid_i = 0, word_last_i = 0;
  logic [31:0] word_data_i = 0;
  logic [1:0]  word_bytes_i = 0;
  logic        word_ready_o, cfg_valid_o, busy_o, done_o;
  logic [31:0] cfg_data_o;
  logic [1:0]  err_o;
  logic [2:0]  summary_o;

  pr_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .encrypt_i(encrypt_i),
    .compress_i(compress_i), .msel_i(msel_i), .ncfg_pin_i(ncfg_pin_i),
    .nstat_pin_i(nstat_pin_i), .cdone_pin_i(cdone_pin_i), .usermode_i(usermode_i),
    .crc_err_i(crc_err_i), .pr_ready_i(pr_ready_i), .pr_done_i(pr_done_i),
    .pr_err_i(pr_err_i), .poll_ivl_i(poll_ivl_i), .burst_start_o(burst_start_o),
    .burst_len_o(burst_len_o), .burst_done_i(burst_done_i), .wide_o(wide_o),
    .ratio_o(ratio_o), .nce_o(nce_o), .port_en_o(port_en_o), .ovr_en_o(ovr_en_o),
    .pr_req_o(pr_req_o), .word_valid_i(word_valid_i), .word_data_i(word_data_i),
    .word_bytes_i(word_bytes_i), .word_last_i(word_last_i),
    .word_ready_o(word_ready_o), .cfg_data_o(cfg_data_o), .cfg_valid_o(cfg_valid_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .summary_o(summary_o)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // burst generator model and output monitors
  logic        clr_mon = 1'b0;
  int          bidx = 0, bdone_cnt = 0, bcnt = 0, ncap = 0;
  logic [11:0] blen [4];
  logic        bpreq [4];
  int          bstart_cyc [4];
  int          bdone_cyc [4];
  logic [31:0] cap [16];

  always @(negedge clk) begin
    if (clr_mon) begin
      bidx = 0; bdone_cnt = 0; bcnt = 0; burst_done_i = 1'b0; ncap = 0;
    end else begin
      burst_done_i = 1'b0;
      if (bcnt != 0) begin
        bcnt--;
        if (bcnt == 0) begin
          burst_done_i = 1'b1;
          if (bdone_cnt < 4) bdone_cyc[bdone_cnt] = cyc;
          bdone_cnt++;
        end
      end
      if (burst_start_o) begin
        if (bidx < 4) begin
          blen[bidx] = burst_len_o;
          bpreq[bidx] = pr_req_o;
          bstart_cyc[bidx] = cyc;
        end
        bidx++;
        bcnt = 3;
      end
      if (cfg_valid_o) begin
        if (ncap < 16) cap[ncap] = cfg_data_o;
        ncap++;
      end
    end
  end

  typedef struct packed {
    logic [2:0] msel;
    logic       ncfg, nstat, enc, cmp;
    logic [7:0] rdy_at;
    logic       rdy_err;
    logic [3:0] nw;
    logic [1:0] lastb;
    logic [7:0] done_at;
    logic       done_err, fin_ok;
    logic [1:0] exp_err, exp_bursts, exp_ratio;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 1'b1, 1'b1, 1'b0, 1'b0,   8'd8, 1'b0, 4'd3, 2'd3,   8'd6, 1'b0, 1'b1, 2'd0, 2'd3, 2'd0},
    '{3'd1, 1'b1, 1'b1, 1'b1, 1'b0,   8'd2, 1'b0, 4'd2, 2'd2,   8'd3, 1'b0, 1'b1, 2'd0, 2'd3, 2'd1},
    '{3'd0, 1'b1, 1'b1, 1'b0, 1'b1,  8'd20, 1'b0, 4'd5, 2'd1,  8'd12, 1'b0, 1'b1, 2'd0, 2'd3, 2'd2},
    '{3'd1, 1'b1, 1'b1, 1'b1, 1'b1,   8'd1, 1'b0, 4'd1, 2'd0,   8'd1, 1'b0, 1'b1, 2'd0, 2'd3, 2'd2},
    '{3'd2, 1'b1, 1'b1, 1'b0, 1'b0,   8'd8, 1'b0, 4'd1, 2'd0,   8'd1, 1'b0, 1'b1, 2'd1, 2'd0, 2'd3},
    '{3'd7, 1'b1, 1'b1, 1'b0, 1'b0,   8'd8, 1'b0, 4'd1, 2'd0,   8'd1, 1'b0, 1'b1, 2'd1, 2'd0, 2'd3},
    '{3'd0, 1'b0, 1'b1, 1'b0, 1'b0,   8'd8, 1'b0, 4'd1, 2'd0,   8'd1, 1'b0, 1'b1, 2'd1, 2'd0, 2'd3},
    '{3'd0, 1'b1, 1'b0, 1'b0, 1'b0,   8'd8, 1'b0, 4'd1, 2'd0,   8'd1, 1'b0, 1'b1, 2'd1, 2'd0, 2'd3},
    '{3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd255, 1'b0, 4'd2, 2'd0,   8'd4, 1'b0, 1'b1, 2'd2, 2'd3, 2'd0},
    '{3'd0, 1'b1, 1'b1, 1'b0, 1'b0,   8'd5, 1'b1, 4'd2, 2'd0,   8'd4, 1'b0, 1'b1, 2'd1, 2'd3, 2'd0},
    '{3'd0, 1'b1, 1'b1, 1'b0, 1'b0,   8'd8, 1'b0, 4'd2, 2'd0, 8'd255, 1'b0, 1'b1, 2'd2, 2'd3, 2'd0},
    '{3'd0, 1'b1, 1'b1, 1'b0, 1'b0,   8'd8, 1'b0, 4'd2, 2'd2,   8'd7, 1'b1, 1'b1, 2'd1, 2'd3, 2'd0},
    '{3'd0, 1'b1, 1'b1, 1'b0, 1'b0,   8'd8, 1'b0, 4'd3, 2'd1,   8'd4, 1'b0, 1'b0, 2'd2, 2'd3, 2'd0}
  };

  function automatic logic [31:0] word_of(input int k, input int i);
    return 32'hF1E2_D3C4 ^ (32'h0101_0101 * i) ^ (k << 4);
  endfunction

  function automatic logic [31:0] mask_of(input logic [1:0] b);
    return (b == 2'd0) ? 32'hFFFF_FFFF : ((32'h1 << (8 * b)) - 1);
  endfunction

  task automatic run_case(input int k, input vec_t v);
    int  c;
    bit  fed;
    fed = 0;
    msel_i = v.msel; ncfg_pin_i = v.ncfg; nstat_pin_i = v.nstat;
    encrypt_i = v.enc; compress_i = v.cmp;
    usermode_i = 0; cdone_pin_i = 0;
    pr_ready_i = 0; pr_done_i = 0; pr_err_i = 0;
    clr_mon = 1; tick(); clr_mon = 0;
    start_i = 1; tick(); start_i = 0;
    if (v.exp_bursts != 0) begin
      // R3: one bring-up step per cycle
      tick();
      check(wide_o == 0 && nce_o == 1, $sformatf("R3 width step case %0d", k), wide_o, 0);
      tick(); tick();
      check(nce_o == 0 && port_en_o == 0, $sformatf("R3 nce step case %0d", k), port_en_o, 0);
      tick();
      check(port_en_o == 1 && ovr_en_o == 0, $sformatf("R3 port step case %0d", k), ovr_en_o, 0);
      tick();
      check(ovr_en_o == 1 && pr_req_o == 0, $sformatf("R3 ovr step case %0d", k), ovr_en_o, 1);
      c = 0;
      while (bdone_cnt < 2 && !done_o && c < 100) begin tick(); c++; end
    end
    c = 0;
    while (!word_ready_o && !done_o && c < 400) begin
      if (c == int'(v.rdy_at)) begin
        if (v.rdy_err) pr_err_i = 1; else pr_ready_i = 1;
      end
      tick(); c++;
    end
    if (word_ready_o) begin
      fed = 1;
      for (int i = 0; i < int'(v.nw); i++) begin
        word_valid_i = 1;
        word_data_i  = word_of(k, i);
        word_last_i  = (i == int'(v.nw) - 1);
        word_bytes_i = word_last_i ? v.lastb : 2'd1;
        tick();
      end
      word_valid_i = 0; word_last_i = 0;
      pr_ready_i = 0;
    end
    usermode_i = v.fin_ok; cdone_pin_i = v.fin_ok;
    c = 0;
    while (!done_o && c < 400) begin
      if (fed && c == int'(v.done_at)) begin
        if (v.done_err) pr_err_i = 1; else pr_done_i = 1;
      end
      tick(); c++;
    end
    check(done_o == 1, $sformatf("R11 done seen case %0d", k), done_o, 1);
    check(err_o == v.exp_err, $sformatf("R1 R2 R5 R9 result case %0d", k), err_o, v.exp_err);
    tick();
    check(done_o == 0, $sformatf("R11 done one cycle case %0d", k), done_o, 0);
    check(nce_o == 1 && port_en_o == 0 && ovr_en_o == 0 && pr_req_o == 0,
          $sformatf("R8 torn down case %0d", k),
          {nce_o, port_en_o, ovr_en_o, pr_req_o}, 4'b1000);
    check(bidx == int'(v.exp_bursts), $sformatf("R4 R8 burst count case %0d", k), bidx, v.exp_bursts);
    if (v.exp_bursts == 2'd3 && bidx == 3) begin
      check(blen[0] == 12'd256 && bpreq[0] == 0, $sformatf("R4 flush burst case %0d", k), blen[0], 256);
      check(blen[1] == 12'd2047 && bpreq[1] == 1, $sformatf("R4 lead burst case %0d", k), blen[1], 2047);
      check(blen[2] == 12'd256 && bpreq[2] == 0, $sformatf("R8 teardown burst case %0d", k), blen[2], 256);
    end
    if (v.exp_ratio != 2'd3)
      check(ratio_o == v.exp_ratio, $sformatf("R3 ratio case %0d", k), ratio_o, v.exp_ratio);
    if (fed) begin
      check(ncap == int'(v.nw), $sformatf("R6 word count case %0d", k), ncap, v.nw);
      for (int i = 0; i < int'(v.nw) - 1 && i < 16; i++)
        check(cap[i] == word_of(k, i), $sformatf("R7 full word case %0d", k), cap[i], word_of(k, i));
      if (ncap >= 1 && ncap <= 16)
        check(cap[ncap-1] == (word_of(k, int'(v.nw) - 1) & mask_of(v.lastb)),
              $sformatf("R6 final mask case %0d", k), cap[ncap-1],
              word_of(k, int'(v.nw) - 1) & mask_of(v.lastb));
    end
    repeat (3) tick();
    check(err_o == v.exp_err, $sformatf("R11 result held case %0d", k), err_o, v.exp_err);
    pr_done_i = 0; pr_err_i = 0; pr_ready_i = 0;
  endtask

  initial begin : main
    vec_t tmo;
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();
    // R11: reset state
    check(nce_o == 1 && wide_o == 1, "R11 reset nce/width", {nce_o, wide_o}, 2'b11);
    check(port_en_o == 0 && ovr_en_o == 0 && pr_req_o == 0 && burst_start_o == 0,
          "R11 reset controls", {port_en_o, ovr_en_o, pr_req_o, burst_start_o}, 0);
    check(done_o == 0 && err_o == 0 && busy_o == 0 && word_ready_o == 0,
          "R11 reset status", {done_o, err_o, busy_o, word_ready_o}, 0);

    for (int k = 0; k < NV; k++) run_case(k, VEC[k]);

    // R5: poll interval spacing, 10 samples at interval 8 before teardown
    poll_ivl_i = 16'd8;
    tmo = VEC[8];
    run_case(100, tmo);
    check(bstart_cyc[2] - bdone_cyc[1] == 82, "R5 timeout gap at interval 8",
          bstart_cyc[2] - bdone_cyc[1], 82);
    poll_ivl_i = 16'd4;

    // R10: status summary priority
    usermode_i = 1; pr_ready_i = 1; crc_err_i = 1; nstat_pin_i = 0; #1;
    check(summary_o == 3'd4, "R10 operating", summary_o, 4);
    usermode_i = 0; #1;
    check(summary_o == 3'd3, "R10 writing", summary_o, 3);
    pr_ready_i = 0; #1;
    check(summary_o == 3'd2, "R10 write error", summary_o, 2);
    crc_err_i = 0; #1;
    check(summary_o == 3'd1, "R10 reset", summary_o, 1);
    nstat_pin_i = 1; #1;
    check(summary_o == 3'd0, "R10 unknown", summary_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule